// File: doc/BRIEF.md
# Configurable DRAM Access Sequencer

This block sits between a simple CPU request port and one memory area. It turns each read or write into either a DRAM cycle or a plain strobed access. The choice depends on a 16-bit control word. A DRAM cycle is a row-address state followed by a column-address phase. The row address and the column address share one multiplexed address bus, and a RAS strobe, a CAS strobe, a read strobe and a write strobe go out with them. The read strobe doubles as the output enable of page-mode parts, so it is low only while read data is valid.

The block runs on a clock at twice the bus rate. One bus state is two clock cycles. The first cycle of each pair is the rising half of the state and the second is the falling half. Halves are counted from the first clock edge after reset is released, starting with a rising half. The control word chooses:
- whether RAS falls at the start of the row state or half a state later;
- whether the column phase lasts two or three states;
- whether the area is DRAM at all;
- whether back-to-back accesses to one row reuse the open row (fast page mode).

The CPU raises `req` with `we`, `addr` and `wdata`, and holds them until `ack` rises. During the single state in which `ack` is high, the CPU either drops `req` or replaces it with the next request. The block samples `req` only at the end of a state, that is, at the edge that closes a falling half. The state machine has five states: IDLE, ROW, COL, NORM and ACK.

- IDLE waits for `req`. When `req` is high it goes to ROW for a DRAM area or to NORM for a plain area.
- ROW always lasts one state and then goes to COL.
- COL counts its states and goes to ACK after the last one.
- NORM lasts two states and then goes to ACK.
- ACK goes back to COL for a page hit. In every other case it goes to IDLE.

Top module: `dram_seq`

## Requirements
- R1: After reset `cfg_rdata` is 0. A write through `cfg_we`/`cfg_wdata` while idle can be read back on `cfg_rdata` one clock later. Every one of the 16 bits reads back as written, spare bits included. The active bits are: bit 14 for early RAS, bit 12 for a long column phase, bit 8 for DRAM area, and bit 7 for page mode.
- R2: During the ROW state `ma` carries `addr[15:8]` and CAS stays high. With bit 14 at 0, RAS is high in the rising half and low in the falling half. With bit 14 at 1, RAS is low in both halves.
- R3: The COL state lasts 2 states when bit 12 is 0 and 3 states when it is 1. Throughout COL, `ma` carries `addr[7:0]` and RAS is low.
- R4: CAS is low only in the last state of COL. On a read, `rd_n` is low in exactly that same window and `wr_n` stays high. On a write, `wr_n` and `dq_oe` are low and high respectively for all of COL, `dq_out` equals `wdata`, and `rd_n` stays high.
- R5: With bit 8 at 0, an access takes 2 NORM states. During NORM, `haddr` carries the full address and `rd_n` (read) or `wr_n` (write) is low. RAS and CAS stay high.
- R6: With bits 8 and 7 both at 1, RAS stays low through ACK. If a request to the same row and in the same direction is present during ACK, it goes straight into COL with no ROW state. Any other request, or no request, sends the block to IDLE with RAS high. A new request then starts its ROW state after one IDLE state.
- R7: `ack` is high for exactly one state, right after COL or NORM. On a read, `rdata` then holds the `dq_in` value sampled at the clock edge that ends the last COL or NORM state.
- R8: A control write during an active cycle leaves `cfg_rdata` and the cycle timing unchanged. It takes effect once the block is back in IDLE.
- R9: With bit 7 at 0, RAS is high in ACK, and every access is a full ROW plus COL cycle, even to the same row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus state rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | CPU access request, held until acknowledged |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW (16) | Access address: row is the upper byte, column is the lower byte |
| wdata | input | DW (16) | Write data |
| ack | output | 1 | High for the one state that ends an access |
| rdata | output | DW (16) | Captured read data |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write value |
| cfg_rdata | output | 16 | Control word currently in effect |
| ma | output | MA_W (8) | Multiplexed row/column address |
| haddr | output | AW (16) | Full latched address for plain-area accesses |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| rd_n | output | 1 | Read strobe / DRAM output enable, active low |
| wr_n | output | 1 | Write strobe, active low |
| dq_out | output | DW (16) | Write data toward memory |
| dq_oe | output | 1 | Write data drive enable |
| dq_in | input | DW (16) | Read data from memory |

## Verification
Accesses are tried under all four pairings of RAS timing and column length, for both reads and writes. This tells the one-half RAS delay apart from the early RAS, and a two-state column phase apart from a three-state one. Page-mode sequences pair a same-row hit with a row change and with a direction change. The hit is then distinguished from both break cases by the presence or absence of the ROW state and of the IDLE gap. The same same-row pair with page mode off shows that RAS is released anyway. Plain-area accesses, a control write that lands in mid-cycle, and a seeded random mix of rows, directions and modes complete the set.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    localparam int CFG_W         = 16;
    localparam int BIT_RAS_EARLY = 14;
    localparam int BIT_COL_LONG  = 12;
    localparam int BIT_DRAM      = 8;
    localparam int BIT_PAGE      = 7;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_NORM = 3'd3,
        ST_ACK  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic ras_early;
        logic col_long;
        logic dram;
        logic page;
    } mode_t;

    function automatic mode_t decode_mode(input logic [CFG_W-1:0] word);
        mode_t m;
        m.ras_early = word[BIT_RAS_EARLY];
        m.col_long  = word[BIT_COL_LONG];
        m.dram      = word[BIT_DRAM];
        m.page      = word[BIT_PAGE];
        return m;
    endfunction

endpackage

// File: rtl/dram_seq_cfg.sv
module dram_seq_cfg
    import dram_seq_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         idle,
    output logic [W-1:0] cfg_q
);

    logic [W-1:0] pend_q;
    logic         pend_v;

    // A write lands at once when idle; otherwise it waits for the next idle cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            pend_q <= '0;
            pend_v <= 1'b0;
        end else if (wr_en && idle) begin
            cfg_q  <= wr_data;
            pend_v <= 1'b0;
        end else if (wr_en) begin
            pend_q <= wr_data;
            pend_v <= 1'b1;
        end else if (pend_v && idle) begin
            cfg_q  <= pend_q;
            pend_v <= 1'b0;
        end
    end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int COL_W     = 8,
    parameter int DW        = 16,
    parameter int COL_SHORT = 2,
    parameter int COL_LONG  = 3,
    parameter int NORM_LEN  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] dq_in,
    input  mode_t         mode,
    output seq_state_e    st,
    output logic          ph,
    output logic          last_col,
    output logic [AW-1:0] addr_q,
    output logic          we_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata
);

    localparam int MAXLEN = (COL_LONG > NORM_LEN) ? COL_LONG : NORM_LEN;
    localparam int CNT_W  = (MAXLEN > 2) ? $clog2(MAXLEN) : 1;
    localparam logic [CNT_W-1:0] END_SHORT = CNT_W'(COL_SHORT - 1);
    localparam logic [CNT_W-1:0] END_LONG  = CNT_W'(COL_LONG - 1);
    localparam logic [CNT_W-1:0] END_NORM  = CNT_W'(NORM_LEN - 1);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ph_q;
    logic             load, cap;
    logic             col_end, norm_end, page_hit;

    assign col_end  = (cnt_q == (mode.col_long ? END_LONG : END_SHORT));
    assign norm_end = (cnt_q == END_NORM);
    assign page_hit = mode.dram && mode.page && req && (we == we_q) &&
                      (addr[AW-1:COL_W] == addr_q[AW-1:COL_W]);

    // Next state: moves only at the edge that closes a falling half.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        load  = 1'b0;
        cap   = 1'b0;
        if (ph_q) begin
            unique case (st_q)
                ST_IDLE: if (req) begin
                    st_d  = mode.dram ? ST_ROW : ST_NORM;
                    cnt_d = '0;
                    load  = 1'b1;
                end
                ST_ROW: begin
                    st_d  = ST_COL;
                    cnt_d = '0;
                end
                ST_COL: if (col_end) begin
                    st_d = ST_ACK;
                    cap  = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
                ST_NORM: if (norm_end) begin
                    st_d = ST_ACK;
                    cap  = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
                ST_ACK: if (page_hit) begin
                    st_d  = ST_COL;
                    cnt_d = '0;
                    load  = 1'b1;
                end else begin
                    st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register, with half-state phase and state counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            ph_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ph_q  <= ~ph_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (load) begin
                addr_q  <= addr;
                we_q    <= we;
                wdata_q <= wdata;
            end
            if (cap && !we_q) begin
                rdata <= dq_in;
            end
        end
    end

    assign st       = st_q;
    assign ph       = ph_q;
    assign last_col = (st_q == ST_COL) && col_end;

endmodule

// File: rtl/dram_seq_pins.sv
module dram_seq_pins
    import dram_seq_pkg::*;
#(
    parameter  int AW    = 16,
    parameter  int COL_W = 8,
    parameter  int DW    = 16,
    localparam int ROW_W = AW - COL_W,
    localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  seq_state_e    st,
    input  logic          ph,
    input  logic          last_col,
    input  mode_t         mode,
    input  logic [AW-1:0] addr_q,
    input  logic          we_q,
    input  logic [DW-1:0] wdata_q,
    output logic          ras_n,
    output logic          cas_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          dq_oe,
    output logic          ack,
    output logic [MA_W-1:0] ma,
    output logic [AW-1:0] haddr,
    output logic [DW-1:0] dq_out
);

    // Output decode: pins are a function of state, phase and latched request.
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        rd_n  = 1'b1;
        wr_n  = 1'b1;
        dq_oe = 1'b0;
        ack   = 1'b0;
        ma    = MA_W'(addr_q[COL_W-1:0]);
        unique case (st)
            ST_IDLE: ;
            ST_ROW: begin
                ma    = MA_W'(addr_q[AW-1:COL_W]);
                ras_n = !(mode.ras_early || ph);
            end
            ST_COL: begin
                ras_n = 1'b0;
                cas_n = !last_col;
                rd_n  = we_q || !last_col;
                wr_n  = !we_q;
                dq_oe = we_q;
            end
            ST_NORM: begin
                rd_n  = we_q;
                wr_n  = !we_q;
                dq_oe = we_q;
            end
            ST_ACK: begin
                ack   = 1'b1;
                ras_n = !(mode.dram && mode.page);
            end
            default: ;
        endcase
    end

    assign haddr  = addr_q;
    assign dq_out = wdata_q;

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_seq_pkg::*;
#(
    parameter  int AW    = 16,
    parameter  int COL_W = 8,
    parameter  int DW    = 16,
    localparam int ROW_W = AW - COL_W,
    localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic             ack,
    output logic [DW-1:0]    rdata,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic [MA_W-1:0]  ma,
    output logic [AW-1:0]    haddr,
    output logic             ras_n,
    output logic             cas_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe,
    input  logic [DW-1:0]    dq_in
);

    seq_state_e       st;
    logic             ph, last_col, we_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic [CFG_W-1:0] cfg_q;
    mode_t            mode;

    assign mode      = decode_mode(cfg_q);
    assign cfg_rdata = cfg_q;

    dram_seq_cfg #(.W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .idle    (st == ST_IDLE),
        .cfg_q   (cfg_q)
    );

    dram_seq_fsm #(.AW(AW), .COL_W(COL_W), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .we       (we),
        .addr     (addr),
        .wdata    (wdata),
        .dq_in    (dq_in),
        .mode     (mode),
        .st       (st),
        .ph       (ph),
        .last_col (last_col),
        .addr_q   (addr_q),
        .we_q     (we_q),
        .wdata_q  (wdata_q),
        .rdata    (rdata)
    );

    dram_seq_pins #(.AW(AW), .COL_W(COL_W), .DW(DW)) u_pins (
        .st       (st),
        .ph       (ph),
        .last_col (last_col),
        .mode     (mode),
        .addr_q   (addr_q),
        .we_q     (we_q),
        .wdata_q  (wdata_q),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .dq_oe    (dq_oe),
        .ack      (ack),
        .ma       (ma),
        .haddr    (haddr),
        .dq_out   (dq_out)
    );

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk
    import dram_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic             dq_oe,
    input logic             ack,
    input seq_state_e       st,
    input logic [CFG_W-1:0] cfg_rdata
);

    assert_cas_inside_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    assert_oe_only_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!wr_n && rd_n));

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> wr_n);

    assert_plain_no_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NORM) |-> (ras_n && cas_n));

    assert_ack_two_halves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |=> ack);

    assert_ack_one_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |=> !ack);

    assert_cfg_frozen_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) != ST_IDLE) |-> $stable(cfg_rdata));

endmodule

bind dram_seq dram_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .dq_oe     (dq_oe),
    .ack       (ack),
    .st        (st),
    .cfg_rdata (cfg_rdata)
);

// File: tb/tb_dram_seq.sv
module tb_dram_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req, we, cfg_we, ack, ras_n, cas_n, rd_n, wr_n, dq_oe;
    logic [15:0] addr, wdata, rdata, cfg_wdata, cfg_rdata, haddr, dq_out, dq_in;
    logic [7:0]  ma;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    logic [15:0] cfg_sh;
    bit   in_ack;
    logic [7:0]  prev_row;
    logic prev_we;

    always #5 clk = ~clk;

    dram_seq dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ack(ack), .rdata(rdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ma(ma), .haddr(haddr), .ras_n(ras_n), .cas_n(cas_n),
        .rd_n(rd_n), .wr_n(wr_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] mk_cfg(input bit re, input bit c3, input bit dr, input bit pg);
        logic [15:0] v = 16'h0000;
        v[14] = re; v[12] = c3; v[8] = dr; v[7] = pg;
        return v;
    endfunction

    // Returns at a rising-half sample point, with the block idle.
    task automatic idle(input int n);
        req = 1'b0;
        repeat (2 * n) @(negedge clk);
        in_ack = 0;
    endtask

    task automatic cfg_write(input logic [15:0] v);
        if (in_ack) idle(1);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R1 readback", cfg_rdata, v);
        @(negedge clk);
        cfg_sh = v;
    endtask

    // Called at a rising-half sample point; returns at the first ACK half.
    task automatic access(input logic [15:0] a, input bit w, input logic [15:0] wd,
                          input bit do_mid, input logic [15:0] mid);
        bit re, c3, dr, pg, cont, was_hold, lst;
        int ncol, lead, body, roff, j, c;
        logic [15:0] din;
        re = cfg_sh[14]; c3 = cfg_sh[12]; dr = cfg_sh[8]; pg = cfg_sh[7];
        ncol     = c3 ? 3 : 2;
        was_hold = in_ack && dr && pg;
        cont     = was_hold && (a[15:8] == prev_row) && (w == prev_we);
        lead     = (!in_ack || cont) ? 2 : 4;
        body     = !dr ? 4 : (cont ? 2 * ncol : 2 + 2 * ncol);
        roff     = cont ? 0 : 2;
        din      = 16'($urandom);
        req = 1'b1; we = w; addr = a; wdata = wd; dq_in = din;
        for (int k = 1; k <= lead + body; k++) begin
            @(negedge clk);
            cfg_we    = do_mid && (k == lead + 1);
            cfg_wdata = mid;
            j = k - lead;
            if (j < 0) begin
                chk(in_ack ? (pg ? "R6 ras across ack" : "R9 ras released") : "R2 idle ras",
                    ras_n, (was_hold && k == 1) ? 0 : 1);
                chk("R7 ack width", ack, (in_ack && k == 1) ? 1 : 0);
            end else if (j == body) begin
                chk("R7 ack", ack, 1);
                chk((dr && pg) ? "R6 ras held in ack" : "R9 ras high in ack", ras_n, !(dr && pg));
                chk("R7 cas high in ack", cas_n, 1);
                if (!w) chk("R7 rdata", rdata, din);
            end else if (!dr) begin
                chk("R5 strobes", {ras_n, cas_n, rd_n, wr_n, dq_oe}, {1'b1, 1'b1, w, !w, w});
                chk("R5 haddr", haddr, a);
                if (w) chk("R5 write data", dq_out, wd);
            end else if (j < roff) begin
                chk("R2 ras timing", ras_n, (j == 0) ? !re : 1'b0);
                chk("R2 row address", ma, a[15:8]);
                chk("R2 cas high", cas_n, 1);
            end else begin
                c   = j - roff;
                lst = (c >= 2 * (ncol - 1));
                chk("R3 ras low", ras_n, 0);
                chk("R3 column address", ma, a[7:0]);
                chk("R4 strobes", {cas_n, rd_n, wr_n, dq_oe}, {!lst, w | !lst, !w, w});
                if (w) chk("R4 write data", dq_out, wd);
            end
            if (do_mid && k == lead + 3) chk("R8 cfg held", cfg_rdata, cfg_sh);
        end
        cfg_we   = 1'b0;
        in_ack   = 1;
        prev_row = a[15:8];
        prev_we  = w;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req = 0; we = 0; addr = 0; wdata = 0; dq_in = 0;
        cfg_we = 0; cfg_wdata = 0; cfg_sh = 0; in_ack = 0; prev_row = 0; prev_we = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset cfg", cfg_rdata, 16'h0000);
        chk("R1 reset pins", {ras_n, cas_n, rd_n, wr_n, ack, dq_oe}, 6'b111100);
        rst_n = 1'b1;

        // R1: every bit, spare ones too
        cfg_write(16'hFFFF);
        cfg_write(16'h5A5A);
        cfg_write(16'h0000);

        // R2, R3, R4: all RAS timing and column length pairings
        for (int m = 0; m < 4; m++) begin
            cfg_write(mk_cfg(m[0], m[1], 1'b1, 1'b0));
            access(16'h3C15, 1'b0, 16'h0, 0, 16'h0);
            access(16'h3C16, 1'b1, 16'hBEEF, 0, 16'h0);
        end
        // R9: same row, page off: full cycles
        access(16'h3C17, 1'b1, 16'h1234, 0, 16'h0);
        idle(1);

        // R5: plain area
        cfg_write(mk_cfg(1'b0, 1'b0, 1'b0, 1'b1));
        access(16'h9876, 1'b0, 16'h0, 0, 16'h0);
        access(16'h9877, 1'b1, 16'hCAFE, 0, 16'h0);

        // R6: page hit, direction break, hit, row break
        cfg_write(mk_cfg(1'b0, 1'b1, 1'b1, 1'b1));
        access(16'h3C10, 1'b0, 16'h0, 0, 16'h0);
        access(16'h3C22, 1'b0, 16'h0, 0, 16'h0);
        access(16'h3C30, 1'b1, 16'h5555, 0, 16'h0);
        access(16'h3C31, 1'b1, 16'hAAAA, 0, 16'h0);
        access(16'h5512, 1'b0, 16'h0, 0, 16'h0);
        idle(1);

        // R8: control write during an active cycle
        cfg_write(mk_cfg(1'b0, 1'b0, 1'b1, 1'b0));
        access(16'h2040, 1'b0, 16'h0, 1, mk_cfg(1'b1, 1'b1, 1'b1, 1'b0));
        idle(2);
        chk("R8 cfg applied after idle", cfg_rdata, mk_cfg(1'b1, 1'b1, 1'b1, 1'b0));
        cfg_sh = mk_cfg(1'b1, 1'b1, 1'b1, 1'b0);
        access(16'h2041, 1'b0, 16'h0, 0, 16'h0);

        // Random mix of rows, directions and modes
        for (int i = 0; i < 80; i++) begin
            logic [7:0] row;
            if (i % 10 == 0)
                cfg_write(mk_cfg(1'($urandom), 1'($urandom), ($urandom % 4) != 0, 1'($urandom)));
            if ($urandom % 4 == 0) idle(1 + $urandom % 2);
            row = ($urandom % 2) ? 8'h3C : 8'hA1;
            access({row, 8'($urandom)}, ($urandom % 3) == 0, 16'($urandom), 0, 16'h0);
        end
        idle(1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule